// File: doc/BRIEF.md
# Steepest-Descent Channel Estimate Updater

This block holds a K×N matrix of signed 8-bit channel estimates and refines it once per received bit with one fixed-step gradient iteration. The step is `A ← A + ((Rbr − Rbb·A) >>> s)`. Here `Rbb` is the K×K autocorrelation matrix of the users' bits and `Rbr` is the K×N cross-correlation of those bits with the received chips. Both matrices live in accumulators outside this block. The block fetches them through address outputs, and the data must come back combinationally in the same cycle. The step is a power of two, so it is applied as an arithmetic right shift by the static input `shift_amt`, and no multiplier is used for it.

The datapath is the pipelined form. It has one signed 8×8 multiplier per column, N in all, and each one sums its products in a saturating 16-bit accumulator. A sequencer walks the K² products one row coefficient per cycle. When a row is finished, the N new estimates for that row are written into a shadow copy. The shadow copy is committed to the visible matrix in a single cycle at the end. Every product therefore uses the old estimates, and a read during an update sees the old matrix. After reset the matrix is all zero. For training, it can be preloaded element by element through a write port while the block is idle.

The sequencer has four states:
- `ST_IDLE`: waiting. `ST_IDLE → ST_MAC` on `start`.
- `ST_MAC`: one product per cycle for row `i`, coefficient `j`. It stays in `ST_MAC` while `j < K-1`. On the last `j` it moves `ST_MAC → ST_ROW`.
- `ST_ROW`: forms and stores the new row. `ST_ROW → ST_MAC` for the next row. `ST_ROW → ST_COMMIT` after row K-1.
- `ST_COMMIT`: copies the shadow to the estimate matrix. `ST_COMMIT → ST_IDLE`, and the move raises `done` for one cycle.

Top module: `chest_sd_update`

## Requirements
- R1: After reset every estimate reads as zero, and `busy` and `done` are low.
- R2: When `busy` is low, a high `wr_en` at a clock edge stores `wr_data` at (`wr_row`, `wr_col`). The read port returns the element at (`rd_row`, `rd_col`) combinationally.
- R3: `start` sampled while idle begins an update. `busy` is high from the next cycle until the update ends. `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R4: Each element (i,n) is updated from a sum over j = 0..K-1 in ascending order of `Rbb[i][j]·A[j][n]`. Each product is 8×8 signed. The sum starts from the j=0 product, and every later addition saturates to the signed 16-bit range. The error is `Rbr[i][n]` minus that sum, also saturated to 16 bits. It is shifted right arithmetically by `shift_amt`, added to `A[i][n]`, and the result is clamped to −128..127.
- R5: All products of one update use the estimates as they were before that update (Jacobi order). The new values become visible all together when `done` rises.
- R6: While `busy` is high, the read port returns the estimates from before the update.
- R7: `wr_en` and `start` have no effect while `busy` is high.
- R8: `done` is high after the K·(K+1)+2-th rising edge, counting the edge that samples `start` as the first.
- R9: During `ST_MAC` the block presents row i and column j on `rbb_row` and `rbb_col`. During `ST_ROW` it presents row i on `rbr_row`. Column n of `rbr_data` occupies bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one update (idle only) |
| shift_amt | input | SW | Step exponent s (arithmetic right shift) |
| rbb_row | output | log2 K | Autocorrelation row address |
| rbb_col | output | log2 K | Autocorrelation column address |
| rbb_data | input | CW | Autocorrelation element, signed |
| rbr_row | output | log2 K | Cross-correlation row address |
| rbr_data | input | N·CW | Cross-correlation row, signed, column n at bits [CW·n+CW-1:CW·n] |
| wr_en | input | 1 | Preload write enable |
| wr_row | input | log2 K | Preload row |
| wr_col | input | log2 N | Preload column |
| wr_data | input | EW | Preload value, signed |
| rd_row | input | log2 K | Read row |
| rd_col | input | log2 N | Read column |
| rd_data | output | EW | Estimate at (rd_row, rd_col), signed |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle end-of-update pulse |

## Verification
The update is swept over every shift value from 0 to 15 with four stimulus families. Small-magnitude values keep all arithmetic in range and test the plain gradient step. Full-range random values exercise the 16-bit accumulator saturation and the 8-bit writeback clamp in mixed directions. A diagonal autocorrelation isolates the cross-correlation path and the shift. Extreme values, with every coefficient at +127 or −128 and estimates near −128, drive the sums to both rails and tell saturation apart from wraparound. In one update the bench also reads and writes in the middle of the run and pulses `start` again, to separate frozen estimates and ignored commands from a design that updates in place or restarts.

// File: rtl/chest_pkg.sv
package chest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MAC    = 2'd1,
        ST_ROW    = 2'd2,
        ST_COMMIT = 2'd3
    } upd_state_t;
endpackage

// File: rtl/chest_lane.sv
// One column lane: multiply-accumulate over the autocorrelation row,
// then form the shifted, saturated estimate update.
module chest_lane #(
    parameter int EW = 8,
    parameter int CW = 8,
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mac_en,
    input  logic                 first,
    input  logic signed [CW-1:0] coef,
    input  logic signed [EW-1:0] est_j,
    input  logic signed [CW-1:0] xc,
    input  logic signed [EW-1:0] est_i,
    input  logic [SW-1:0]        shamt,
    output logic signed [EW-1:0] new_est
);
    localparam int PW = CW + EW;
    localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};
    localparam logic signed [EW-1:0] EMAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic signed [EW-1:0] EMIN = {1'b1, {(EW-1){1'b0}}};

    function automatic logic signed [AW-1:0] sat_acc(input logic signed [AW:0] v);
        if (v[AW] != v[AW-1]) return v[AW] ? AMIN : AMAX;
        return v[AW-1:0];
    endfunction

    function automatic logic signed [EW-1:0] sat_est(input logic signed [AW:0] v);
        logic [AW-EW+1:0] hi;
        hi = v[AW:EW-1];
        if ((&hi) || !(|hi)) return v[EW-1:0];
        return v[AW] ? EMIN : EMAX;
    endfunction

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x, acc_q, acc_d, err, step;
    logic signed [AW:0]   sum_w, diff_w, upd_w;

    assign prod   = coef * est_j;
    assign prod_x = AW'(prod);
    assign sum_w  = (AW+1)'(acc_q) + (AW+1)'(prod_x);
    assign acc_d  = first ? prod_x : sat_acc(sum_w);
    assign diff_w = (AW+1)'(xc) - (AW+1)'(acc_q);
    assign err    = sat_acc(diff_w);
    assign step   = err >>> shamt;
    assign upd_w  = (AW+1)'(est_i) + (AW+1)'(step);
    assign new_est = sat_est(upd_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (mac_en) acc_q <= acc_d;
    end

    // R4: a sum pinned at a rail stays there while same-signed products arrive
    a_r4_acc_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && !first && acc_q == AMAX && !prod_x[AW-1]) |=> acc_q == AMAX);
    a_r4_acc_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && !first && acc_q == AMIN && prod_x[AW-1]) |=> acc_q == AMIN);
endmodule

// File: rtl/chest_seq.sv
// Sequencer: walks row i and coefficient j over the K*K products.
module chest_seq
    import chest_pkg::*;
#(
    parameter int K  = 4,
    parameter int IW = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [IW-1:0] row,
    output logic [IW-1:0] col,
    output logic          first,
    output logic          mac_en,
    output logic          row_en,
    output logic          commit_en,
    output logic          busy,
    output logic          done
);
    localparam logic [IW-1:0] LAST = IW'(K - 1);

    upd_state_t state_q, state_d;
    logic [IW-1:0] ri_q, cj_q;
    logic done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_MAC;
            ST_MAC:    if (cj_q == LAST) state_d = ST_ROW;
            ST_ROW:    state_d = (ri_q == LAST) ? ST_COMMIT : ST_MAC;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ri_q    <= '0;
            cj_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_COMMIT);
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ri_q <= '0;
                    cj_q <= '0;
                end
                ST_MAC:  cj_q <= (cj_q == LAST) ? '0 : cj_q + 1'b1;
                ST_ROW:  if (ri_q != LAST) ri_q <= ri_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        row       = ri_q;
        col       = cj_q;
        first     = (cj_q == '0);
        mac_en    = (state_q == ST_MAC);
        row_en    = (state_q == ST_ROW);
        commit_en = (state_q == ST_COMMIT);
        busy      = (state_q != ST_IDLE);
        done      = done_q;
    end

    // R3: done lasts one cycle and follows the commit with busy low
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (done && !busy));
    // R7: an update in flight is never cut short
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit_en) |=> busy);
endmodule

// File: rtl/chest_sd_update.sv
module chest_sd_update
    import chest_pkg::*;
#(
    parameter int K  = 4,
    parameter int N  = 4,
    parameter int EW = 8,
    parameter int CW = 8,
    parameter int AW = 16,
    parameter int SW = 4,
    parameter int IW = (K > 1) ? $clog2(K) : 1,
    parameter int NW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SW-1:0]   shift_amt,
    output logic [IW-1:0]   rbb_row,
    output logic [IW-1:0]   rbb_col,
    input  logic [CW-1:0]   rbb_data,
    output logic [IW-1:0]   rbr_row,
    input  logic [N*CW-1:0] rbr_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_row,
    input  logic [NW-1:0]   wr_col,
    input  logic [EW-1:0]   wr_data,
    input  logic [IW-1:0]   rd_row,
    input  logic [NW-1:0]   rd_col,
    output logic [EW-1:0]   rd_data,
    output logic            busy,
    output logic            done
);
    logic [IW-1:0] row, col;
    logic first, mac_en, row_en, commit_en;

    logic signed [EW-1:0] est_q  [K][N];
    logic signed [EW-1:0] shad_q [K][N];
    logic signed [EW-1:0] lane_new [N];
    logic [K*N*EW-1:0] est_flat;

    chest_seq #(.K(K), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .row(row), .col(col), .first(first),
        .mac_en(mac_en), .row_en(row_en), .commit_en(commit_en),
        .busy(busy), .done(done)
    );

    for (genvar n = 0; n < N; n++) begin : g_lane
        chest_lane #(.EW(EW), .CW(CW), .AW(AW), .SW(SW)) u_lane (
            .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .first(first),
            .coef(rbb_data),
            .est_j(est_q[col][n]),
            .xc(rbr_data[n*CW +: CW]),
            .est_i(est_q[row][n]),
            .shamt(shift_amt),
            .new_est(lane_new[n])
        );
    end

    for (genvar i = 0; i < K; i++) begin : g_flat_r
        for (genvar n = 0; n < N; n++) begin : g_flat_c
            assign est_flat[(i*N+n)*EW +: EW] = est_q[i][n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < K; i++)
                for (int n = 0; n < N; n++) begin
                    est_q[i][n]  <= '0;
                    shad_q[i][n] <= '0;
                end
        end else begin
            if (row_en)
                for (int n = 0; n < N; n++) shad_q[row][n] <= lane_new[n];
            if (commit_en)
                est_q <= shad_q;
            else if (wr_en && !busy)
                est_q[wr_row][wr_col] <= wr_data;
        end
    end

    assign rbb_row = row;
    assign rbb_col = col;
    assign rbr_row = row;
    assign rd_data = est_q[rd_row][rd_col];

    // R6, R7: the visible matrix only changes at commit while busy
    a_r6_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit_en) |=> $stable(est_flat));
    // R2: an idle write lands at its address
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> est_q[$past(wr_row)][$past(wr_col)] == $past(wr_data));
endmodule

// File: tb/sim_chest_sd_update.sv
`timescale 1ns/1ps
module sim_chest_sd_update;
    localparam int K = 4;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] shift_amt = '0;
    logic [1:0] rbb_row, rbb_col, rbr_row;
    logic [7:0] rbb_data;
    logic [N*8-1:0] rbr_data;
    logic wr_en = 1'b0;
    logic [1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic busy, done;

    int checks = 0, bad = 0;
    int rbb_m [K][K];
    int rbr_m [K][N];
    int est_m [K][N];
    int exp_m [K][N];
    int unsigned lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    chest_sd_update u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .shift_amt(shift_amt),
        .rbb_row(rbb_row), .rbb_col(rbb_col), .rbb_data(rbb_data),
        .rbr_row(rbr_row), .rbr_data(rbr_data),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    always_comb begin
        rbb_data = 8'(rbb_m[rbb_row][rbb_col]);
        for (int n = 0; n < N; n++) rbr_data[n*8 +: 8] = 8'(rbr_m[rbr_row][n]);
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lo + int'(lfsr % 32'(hi - lo + 1));
    endfunction

    function automatic int clampv(input int v, input int lo, input int hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    // R4, R5: expected matrix from the old estimates only
    task automatic model(input int s);
        for (int i = 0; i < K; i++)
            for (int n = 0; n < N; n++) begin
                int acc, err;
                acc = 0;
                for (int j = 0; j < K; j++) begin
                    if (j == 0) acc = rbb_m[i][j] * est_m[j][n];
                    else acc = clampv(acc + rbb_m[i][j] * est_m[j][n], -32768, 32767);
                end
                err = clampv(rbr_m[i][n] - acc, -32768, 32767);
                exp_m[i][n] = clampv(est_m[i][n] + (err >>> s), -128, 127);
            end
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++)
                unique case (mode)
                    0: rbb_m[i][j] = rnd(-8, 7);
                    1: rbb_m[i][j] = rnd(-128, 127);
                    2: rbb_m[i][j] = (i == j) ? 1 : 0;
                    default: rbb_m[i][j] = (rnd(0, 1) == 1) ? 127 : -128;
                endcase
            for (int n = 0; n < N; n++)
                unique case (mode)
                    0: begin rbr_m[i][n] = rnd(-16, 15); est_m[i][n] = rnd(-8, 7); end
                    1: begin rbr_m[i][n] = rnd(-128, 127); est_m[i][n] = rnd(-128, 127); end
                    2: begin rbr_m[i][n] = rnd(-128, 127); est_m[i][n] = rnd(-128, 127); end
                    default: begin rbr_m[i][n] = rnd(-128, 127); est_m[i][n] = rnd(-128, -120); end
                endcase
        end
    endtask

    task automatic preload();
        for (int i = 0; i < K; i++)
            for (int n = 0; n < N; n++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_row = 2'(i); wr_col = 2'(n); wr_data = 8'(est_m[i][n]);
            end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_update(input int s, input int mode, input bit probe);
        int cnt;
        fill(mode);
        preload();
        model(s);
        shift_amt = 4'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 100) begin
            if (probe && cnt == 3) begin
                rd_row = 2'd1; rd_col = 2'd2;
                #0.5;
                check("R6 read during update", int'($signed(rd_data)), est_m[1][2]);
                check("R3 busy mid update", int'(busy), 1);
                wr_en = 1'b1; wr_row = 2'd0; wr_col = 2'd0; wr_data = 8'sd55;
                start = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0;
            start = 1'b0;
            cnt++;
        end
        check("R8 done edge count", cnt, K*(K+1)+2);
        check("R3 busy low with done", int'(busy), 0);
        @(negedge clk);
        check("R3 done one cycle", int'(done), 0);
        check("R7 start while busy ignored", int'(busy), 0);
        for (int i = 0; i < K; i++)
            for (int n = 0; n < N; n++) begin
                rd_row = 2'(i); rd_col = 2'(n);
                #0.5;
                // R4, R5, R9 (and R7 when probing)
                check(mode == 3 ? "R4 saturating update" : "R4 R5 R9 element",
                      int'($signed(rd_data)), exp_m[i][n]);
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < K; i++) for (int j = 0; j < K; j++) rbb_m[i][j] = 0;
        for (int i = 0; i < K; i++) for (int n = 0; n < N; n++) rbr_m[i][n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 done at reset", int'(done), 0);
        for (int i = 0; i < K; i++)
            for (int n = 0; n < N; n++) begin
                rd_row = 2'(i); rd_col = 2'(n);
                #0.5;
                check("R1 zero estimate", int'($signed(rd_data)), 0);
            end
        // R2: preload and read back
        fill(1);
        preload();
        for (int i = 0; i < K; i++)
            for (int n = 0; n < N; n++) begin
                rd_row = 2'(i); rd_col = 2'(n);
                #0.5;
                check("R2 preload readback", int'($signed(rd_data)), est_m[i][n]);
            end
        // R6, R7 probe on one update, then sweep shift and pattern
        run_update(2, 1, 1'b1);
        for (int s = 0; s < 16; s++)
            for (int m = 0; m < 4; m++)
                run_update(s, m, 1'b0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule